// File: doc/BRIEF.md
# Serial two-wire configuration register slave

This block lets an external two-wire bus master reach a bank of 142 eight-bit configuration registers. It contains the line synchronizer, the bit-level engine, device-address matching, an auto-incrementing register pointer and the storage itself. The master addresses the block the way it would address a small serial EEPROM. It first sends a device byte, then a byte that loads the pointer, then any number of data bytes. A read transfer returns bytes starting at the pointer that an earlier write left behind.

Register 1, bit 0 is a run latch that the surrounding logic watches. Once a 1 has been written to it, nothing but reset clears it. The other seven bits of register 1 act as ordinary storage. The system clock samples SCL and SDA through two-stage synchronizers. The slave never stretches the clock. Its only output toward the bus is an open-drain pull-down enable for SDA.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the device byte 0xBE as a write transfer and 0xBF as a read transfer. An acknowledge means SDA is held low during the ninth clock.
- R2: After any other device byte the slave stays silent. It sends no acknowledge and never drives SDA, and it neither stores data nor moves the pointer until the next START.
- R3: In a write transfer, the byte after the device byte loads the register pointer. Each following byte is stored at the pointer, and both kinds of byte are acknowledged.
- R4: A read transfer returns the byte at the current pointer. The pointer is the one set by a preceding write, and the data is shifted out MSB first.
- R5: The pointer advances by one after every data byte read or written. After address 141 it wraps to 0.
- R6: Bytes written at pointer values of 142 and above are acknowledged and dropped, and reads there return 0x00. From any pointer value of 141 or higher the pointer moves next to 0.
- R7: Register 1 bit 0 (output run_en) starts at 0. A write of 1 sets it, and later writes of 0 leave it set. Bits 7..1 of register 1 take the written value.
- R8: When the master answers a read byte with NACK, the slave releases SDA. A STOP returns the slave to idle, and a START begins a fresh transfer.
- R9: After reset every register reads 0x00, SDA is released and run_en is 0.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| run_en | output | 1 | Run latch, register 1 bit 0 |

## Verification
The hardest case to reach is the point where the pointer crosses the irregular map end, since wrap and discard happen only at or above 141. Directed transfers begin at 140 and at 150 and run across that edge. The random transfers then draw start addresses from 0 to 159, so bursts regularly cross the top of the map. A repeated START between the pointer load and the read, and a NACK on the last byte, are used in every readback.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned REG_COUNT = 142;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned ADDR_W    = 8;
    localparam logic [7:0]  DEV_WR    = 8'hBE;
    localparam logic [7:0]  DEV_RD    = 8'hBF;
    localparam int unsigned RUN_REG   = 1;
    localparam int unsigned RUN_BIT   = 0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        BY_DEV,
        BY_REG,
        BY_DATA
    } byte_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Pointer advance: anything at or beyond the last register wraps to 0.
    function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
        if (p >= ADDR_W'(REG_COUNT - 1))
            return '0;
        return p + 1'b1;
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [1:0] line_s;
    logic [1:0] line_d;
    logic       scl_s;

    // One synchronizer chain per bus line; index 0 is SCL, 1 is SDA.
    for (genvar l = 0; l < 2; l++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain     <= '1;
                line_d[l] <= 1'b1;
            end else begin
                chain     <= {chain[STAGES-2:0], (l == 0) ? scl_i : sda_i};
                line_d[l] <= chain[STAGES-1];
            end
        end
        assign line_s[l] = chain[STAGES-1];
    end

    assign scl_s     = line_s[0];
    assign sda_s     = line_s[1];
    assign scl_rise  = scl_s & ~line_d[0];
    assign scl_fall  = ~scl_s & line_d[0];
    assign start_det = scl_s & line_d[0] & line_d[1] & ~sda_s;
    assign stop_det  = scl_s & line_d[0] & ~line_d[1] & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import cfg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr_req,
    output logic              sda_oe
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    phase_e             phase;
    byte_e              kind;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  shreg;
    logic [DATA_W-1:0]  txreg;
    logic [ADDR_W-1:0]  ptr;
    logic               rd_mode;
    logic               more;

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        wr_req.en <= 1'b0;
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= BY_DEV;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            rd_mode <= 1'b0;
            more    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_req  <= '0;
        end else if (start_det) begin
            phase  <= PH_RX;
            kind   <= BY_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (phase)
                PH_RX: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == LAST) begin
                        cnt <= '0;
                        unique case (kind)
                            BY_DEV: begin
                                if (shreg == DEV_WR || shreg == DEV_RD) begin
                                    rd_mode <= (shreg == DEV_RD);
                                    sda_oe  <= 1'b1;
                                    phase   <= PH_RX_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            BY_REG: begin
                                ptr    <= ADDR_W'(shreg);
                                sda_oe <= 1'b1;
                                phase  <= PH_RX_ACK;
                            end
                            default: begin
                                wr_req <= '{en: 1'b1, addr: ptr, data: shreg};
                                ptr    <= ptr_next(ptr);
                                sda_oe <= 1'b1;
                                phase  <= PH_RX_ACK;
                            end
                        endcase
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        if (kind == BY_DEV && rd_mode) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            ptr    <= ptr_next(ptr);
                            phase  <= PH_TX;
                        end else begin
                            kind  <= (kind == BY_DEV) ? BY_REG : BY_DATA;
                            phase <= PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            phase  <= PH_TX_ACK;
                        end else begin
                            txreg  <= {txreg[DATA_W-2:0], 1'b0};
                            sda_oe <= ~txreg[DATA_W-2];
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise) begin
                        more <= ~sda_s;
                    end else if (scl_fall) begin
                        if (more) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            ptr    <= ptr_next(ptr);
                            phase  <= PH_TX;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              run_flag
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << RUN_BIT;

    logic [DATA_W-1:0] regs [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit = wr_req.en && (wr_req.addr == ADDR_W'(g));
        if (g == RUN_REG) begin : g_run
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (hit)
                    q <= wr_req.data | (q & KEEP_MASK);
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (hit)
                    q <= wr_req.data;
            end
        end
        assign regs[g] = q;
    end

    assign rd_data  = (rd_addr < ADDR_W'(REG_COUNT)) ? regs[rd_addr] : '0;
    assign run_flag = regs[RUN_REG][RUN_BIT];
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic run_en
);
    timeunit 1ns;
    timeprecision 100ps;

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    wr_req_t           wr_req;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_byte_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_req   (wr_req),
        .sda_oe   (sda_oe)
    );

    cfg_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .run_flag(run_en)
    );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_oe,
    input logic run_en,
    input logic start_det,
    input logic stop_det
);
    timeunit 1ns;
    timeprecision 100ps;

    // R7
    run_latch_chk: assert property (@(posedge clk) disable iff (rst) run_en |=> run_en);

    // R10
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> !scl_i);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe);

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (rst) start_det |=> !sda_oe);

    // R9
    reset_state_chk: assert property (@(posedge clk) rst |=> (!sda_oe && !run_en));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .run_en   (run_en),
    .start_det(start_det),
    .stop_det (stop_det)
);

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int Q      = 25;
    localparam int NREG   = 142;
    localparam int WD_CYC = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_low = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic run_en;

    int n_chk = 0;
    int n_fail = 0;
    int r10_bad = 0;
    logic oe_prev = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [16];

    always #2.5 clk = ~clk;

    assign sda_line = ~(sda_low | sda_oe);

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_m),
        .sda_i (sda_line),
        .sda_oe(sda_oe),
        .run_en(run_en)
    );

    // R10 monitor: drive must not change while the master holds SCL high
    always begin
        @(posedge clk);
        #1;
        if (!rst && sda_oe != oe_prev && scl_m) r10_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nxt(input int p);
        return (p >= NREG - 1) ? 0 : p + 1;
    endfunction

    function automatic void model_wr(input int p, input logic [7:0] d);
        if (p < NREG) begin
            if (p == 1) model[1] = d | (model[1] & 8'h01);
            else model[p] = d;
        end
    endfunction

    function automatic logic [7:0] model_rd(input int p);
        return (p < NREG) ? model[p] : 8'h00;
    endfunction

    task automatic bus_start();
        sda_low = 1'b0; #Q;
        scl_m = 1'b1;   #Q;
        sda_low = 1'b1; #Q;
        scl_m = 1'b0;   #Q;
    endtask

    task automatic bus_stop();
        sda_low = 1'b1; #Q;
        scl_m = 1'b1;   #Q;
        sda_low = 1'b0; #Q;
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_low = ~b[i]; #Q;
            scl_m = 1'b1;    #Q; #Q;
            scl_m = 1'b0;    #Q;
        end
        sda_low = 1'b0; #Q;
        scl_m = 1'b1;   #Q;
        acked = (sda_line == 1'b0);
        #Q;
        scl_m = 1'b0;   #Q;
    endtask

    task automatic get_byte(input bit ack, output logic [7:0] b);
        b = '0;
        sda_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            #Q; scl_m = 1'b1;
            #Q; b = {b[6:0], sda_line};
            #Q; scl_m = 1'b0;
            #Q;
        end
        sda_low = ack; #Q;
        scl_m = 1'b1;  #Q; #Q;
        scl_m = 1'b0;  #Q;
        sda_low = 1'b0;
    endtask

    task automatic wr_seq(input int a, input int n, input string tag);
        bit k;
        int p;
        p = a;
        bus_start();
        put_byte(8'hBE, k); chk(k, "R1 write device ack", k, 1);
        put_byte(8'(a), k); chk(k, "R3 pointer byte ack", k, 1);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], k); chk(k, tag, k, 1);
            model_wr(p, wbuf[i]);
            p = nxt(p);
        end
        bus_stop();
    endtask

    task automatic rd_seq(input int a, input int n, input string tag);
        bit k;
        int p;
        logic [7:0] b;
        p = a;
        bus_start();
        put_byte(8'hBE, k);
        put_byte(8'(a), k); chk(k, "R3 pointer byte ack", k, 1);
        bus_start();
        put_byte(8'hBF, k); chk(k, "R1 read device ack", k, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            chk(b == model_rd(p), tag, b, model_rd(p));
            p = nxt(p);
        end
        #Q;
        chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 idle after STOP", sda_oe, 0);
    endtask

    initial begin
        #(WD_CYC * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit k;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R9: reset state
        chk(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
        chk(run_en == 1'b0, "R9 run_en low", run_en, 0);
        rd_seq(0, 4, "R9 reset contents");

        // R2: foreign device byte ignored, nothing stored
        bus_start();
        put_byte(8'hA0, k); chk(!k, "R2 no ack foreign address", k, 0);
        put_byte(8'h05, k); chk(!k, "R2 no ack after mismatch", k, 0);
        put_byte(8'h55, k); chk(!k, "R2 no ack on data", k, 0);
        bus_stop();
        bus_start();
        put_byte(8'hBD, k); chk(!k, "R2 no ack near-miss address", k, 0);
        bus_stop();
        rd_seq(5, 1, "R2 register untouched");

        // R3/R4: burst write then readback, MSB first
        wbuf[0] = 8'h81; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
        wr_seq(10, 3, "R3 data ack");
        rd_seq(10, 3, "R4 readback MSB first");

        // R5: wrap past the last register
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
        wr_seq(140, 3, "R5 data ack across wrap");
        rd_seq(140, 4, "R5 wrap read 140..1");

        // R6: out-of-map addresses
        wbuf[0] = 8'h77; wbuf[1] = 8'h66;
        wr_seq(150, 2, "R6 ack above map");
        rd_seq(150, 2, "R6 zero above map then wrap to 0");
        rd_seq(200, 1, "R6 zero far above map");

        // R7: run latch
        wbuf[0] = 8'hFE;
        wr_seq(1, 1, "R7 data ack");
        chk(run_en == 1'b0, "R7 bit0 stays 0", run_en, 0);
        rd_seq(1, 1, "R7 upper bits stored");
        wbuf[0] = 8'h01;
        wr_seq(1, 1, "R7 data ack");
        chk(run_en == 1'b1, "R7 set by write of 1", run_en, 1);
        wbuf[0] = 8'hA0;
        wr_seq(1, 1, "R7 data ack");
        chk(run_en == 1'b1, "R7 not cleared by write of 0", run_en, 1);
        rd_seq(1, 1, "R7 readback keeps bit0");

        // Random bursts, including ones crossing the map end (R5, R6)
        for (int t = 0; t < 16; t++) begin
            int a, n;
            a = $urandom_range(0, 159);
            n = $urandom_range(1, 6);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_seq(a, n, "R3 random data ack");
            a = $urandom_range(0, 159);
            n = $urandom_range(1, 8);
            rd_seq(a, n, "R5 random readback");
        end
        chk(run_en == model[1][0], "R7 run_en after random", run_en, model[1][0]);

        chk(r10_bad == 0, "R10 drive change with SCL high", r10_bad, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule